// File: doc/BRIEF.md
# Bit-6 Address Swizzle Unit

This unit rewrites physical byte addresses of tiled surfaces so that the view a requester has of memory matches the channel interleave used by the memory controller. Each address arrives with a tiling kind: linear, X-tiled or Y-tiled. Address bit 6 is replaced by the XOR of itself with a set of higher address bits. The set depends on the tiling kind and on the active swizzle mode. Every other address bit passes through untouched.

The swizzle mode is not programmed directly. It is decoded from a memory-configuration word that is supplied as a plain input. That word states the channel arrangement and how the CPU-side channel XOR is set up. A relocation flag adds a second correction. A page whose address bit 17 has changed since its contents were laid out has the two 64-byte halves of every 128-byte block exchanged. The unit does this by inverting bit 6 for accesses to that page.

Addresses flow in and out over valid/ready. A parameter selects between a purely combinational path and a single register stage. In the registered variant an accepted address appears one cycle later. The registered output holds steady while the consumer keeps ready low. The input accepts a new address whenever the stage is empty or its content leaves in the same cycle, so back-pressure reaches the producer in the same cycle. The configuration pins are plain levels, sampled together with each accepted address.

Top module: `addr_swizzle_unit`

## Requirements
- R1: For a tiling code of 0 (linear) or 3 (reserved), and for mode code 0 (none), the output address equals the input address, unless a relocation flip applies (R7).
- R2: In mode code 1 (base interleave), an X-tiled address (tiling code 1) gets bit 6 XORed with bits 9 and 10. A Y-tiled address (tiling code 2) gets bit 6 XORed with bit 9 only.
- R3: In mode code 2, an X-tiled address gets bit 6 XORed with bits 9, 10 and 11. A Y-tiled address gets bit 6 XORed with bits 9 and 11.
- R4: In mode code 3, an X-tiled address gets bit 6 XORed with bits 9, 10 and 17. A Y-tiled address gets bit 6 XORed with bits 9 and 17.
- R5: The configuration word decodes as follows. Bits [1:0] give the channel arrangement: 0 single channel, 1 asymmetric dual, 2 interleaved dual. Arrangements 0 and 1 give mode 0. For arrangement 2, bit 2 set (CPU XOR off) gives mode 1. Otherwise bit 3 set gives mode 3 and bit 3 clear gives mode 2. The decoded code is shown on `mode_code`.
- R6: A configuration word of all ones, or arrangement 3, decodes to mode code 7 (unknown) and raises `cfg_unknown`. Mode 7 swizzles like mode 0.
- R7: When `in_reloc` is 1 and `in_saved_b17` differs from address bit 17, bit 6 is additionally inverted. Otherwise relocation has no effect.
- R8: No output bit other than bit 6 ever differs from the corresponding input bit.
- R9: With the register stage enabled, an address accepted on a clock edge is presented with `out_valid` high after that edge. While `out_ready` is low, `out_valid` and `out_addr` hold. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | CFG_W | Memory-configuration word (R5 fields) |
| mode_code | output | 3 | Decoded swizzle mode |
| cfg_unknown | output | 1 | Configuration could not be interpreted |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Unit can accept an address |
| in_addr | input | ADDR_W | Physical byte address |
| in_tile | input | 2 | Tiling code: 0 linear, 1 X, 2 Y, 3 reserved |
| in_reloc | input | 1 | Relocation check enabled for this access |
| in_saved_b17 | input | 1 | Bit 17 the page had when its contents were written |
| out_valid | output | 1 | Output address valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_addr | output | ADDR_W | Swizzled address |

## Verification
The assertions watch every cycle for three things. No bit other than bit 6 changes. Linear, reserved and unknown-mode accesses pass unchanged when no relocation applies. The output stage accepts, holds and presents data as the handshake rules require. The exact XOR sets for each mode and tiling kind can only be shown by the bench scenarios, which compare against a reference model. The same holds for the decode of each configuration word, the relocation flip, and the ordering and completeness of addresses under random back-pressure.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE    = 3'd0,
    SWZ_BASE    = 3'd1,
    SWZ_B11     = 3'd2,
    SWZ_B17     = 3'd3,
    SWZ_UNKNOWN = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    CHAN_SINGLE = 2'd0,
    CHAN_ASYM   = 2'd1,
    CHAN_ILV    = 2'd2,
    CHAN_RSVD   = 2'd3
  } chan_e;

  // address bit positions involved in the swizzle
  localparam int unsigned TGT_BIT = 6;
  localparam int unsigned TAP_A   = 9;
  localparam int unsigned TAP_B   = 10;
  localparam int unsigned TAP_C   = 11;
  localparam int unsigned TAP_D   = 17;

  // configuration word field positions
  localparam int unsigned CFG_CHAN_LO = 0;
  localparam int unsigned CFG_XOR_OFF = 2;
  localparam int unsigned CFG_XOR_B17 = 3;

endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
  import swz_pkg::*;
#(
  parameter int unsigned CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg_word,
  output swz_mode_e        mode,
  output logic             unknown
);

  chan_e chan;
  logic  all_ones;

  assign chan     = chan_e'(cfg_word[CFG_CHAN_LO +: 2]);
  assign all_ones = &cfg_word;

  always_comb begin
    mode = SWZ_NONE;
    unique case (chan)
      CHAN_SINGLE, CHAN_ASYM: mode = SWZ_NONE;
      CHAN_ILV: begin
        if (cfg_word[CFG_XOR_OFF])      mode = SWZ_BASE;
        else if (cfg_word[CFG_XOR_B17]) mode = SWZ_B17;
        else                            mode = SWZ_B11;
      end
      CHAN_RSVD: mode = SWZ_UNKNOWN;
    endcase
    if (all_ones) mode = SWZ_UNKNOWN;
  end

  assign unknown = (mode == SWZ_UNKNOWN);

endmodule

// File: rtl/swz_bit6_core.sv
module swz_bit6_core
  import swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  tile_e             tile,
  input  swz_mode_e         mode,
  input  logic              reloc,
  input  logic              saved_b17,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned NTAP = 4;

  // tap order: bit 9, bit 10, bit 11, bit 17
  logic [NTAP-1:0] tap_val;
  logic [NTAP-1:0] tap_sel;
  logic            swz_flip;
  logic            rel_flip;

  assign tap_val = {addr_i[TAP_D], addr_i[TAP_C], addr_i[TAP_B], addr_i[TAP_A]};

  always_comb begin
    logic [NTAP-1:0] extra;
    extra   = '0;
    tap_sel = '0;
    unique case (mode)
      SWZ_B11: extra = 4'b0100;
      SWZ_B17: extra = 4'b1000;
      default: extra = 4'b0000;
    endcase
    if (mode == SWZ_BASE || mode == SWZ_B11 || mode == SWZ_B17) begin
      unique case (tile)
        TILE_X:  tap_sel = 4'b0011 | extra;
        TILE_Y:  tap_sel = 4'b0001 | extra;
        default: tap_sel = '0;
      endcase
    end
  end

  assign swz_flip = ^(tap_val & tap_sel);
  assign rel_flip = reloc & (saved_b17 ^ addr_i[TAP_D]);

  always_comb begin
    addr_o          = addr_i;
    addr_o[TGT_BIT] = addr_i[TGT_BIT] ^ swz_flip ^ rel_flip;
  end

endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
  parameter int unsigned W    = 40,
  parameter bit          PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  generate
    if (PIPE) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end

      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

      p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_ready) |=> !out_valid);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/addr_swizzle_unit.sv
module addr_swizzle_unit
  import swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned CFG_W  = 32,
  parameter bit          PIPE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [2:0]        mode_code,
  output logic              cfg_unknown,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_tile,
  input  logic              in_reloc,
  input  logic              in_saved_b17,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << TGT_BIT);

  swz_mode_e         mode;
  logic              unknown;
  logic [ADDR_W-1:0] swz_addr;

  swz_cfg_decode #(.CFG_W(CFG_W)) u_dec (
    .cfg_word (cfg_word),
    .mode     (mode),
    .unknown  (unknown)
  );

  swz_bit6_core #(.ADDR_W(ADDR_W)) u_core (
    .addr_i    (in_addr),
    .tile      (tile_e'(in_tile)),
    .mode      (mode),
    .reloc     (in_reloc),
    .saved_b17 (in_saved_b17),
    .addr_o    (swz_addr)
  );

  swz_out_stage #(.W(ADDR_W), .PIPE(PIPE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (swz_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_addr)
  );

  assign mode_code   = mode;
  assign cfg_unknown = unknown;

  p_only_bit6_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (((swz_addr ^ in_addr) & KEEP_MASK) == '0));

  p_untiled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_reloc && (in_tile == 2'd0 || in_tile == 2'd3)) |-> (swz_addr == in_addr));

  p_unknown_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_reloc && cfg_unknown) |-> (swz_addr == in_addr && mode_code == 3'd7));

  p_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_reloc && mode_code == 3'd0) |-> (swz_addr == in_addr));

endmodule

// File: tb/tb_addr_swizzle_unit.sv
module tb_addr_swizzle_unit;

  localparam int AW = 40;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_word = '0;
  logic [2:0]    mode_code;
  logic          cfg_unknown;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_tile = '0;
  logic          in_reloc = 1'b0;
  logic          in_saved_b17 = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [AW-1:0] expq[$];

  always #5 clk = ~clk;

  addr_swizzle_unit #(.ADDR_W(AW), .CFG_W(CW), .PIPE(1'b1)) dut (.*);

  function automatic logic [2:0] ref_mode(logic [CW-1:0] w);
    if (w == '1) return 3'd7;
    case (w[1:0])
      2'd0, 2'd1: return 3'd0;
      2'd2: return w[2] ? 3'd1 : (w[3] ? 3'd3 : 3'd2);
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [AW-1:0] ref_addr(logic [AW-1:0] a, logic [1:0] t,
                                             logic [2:0] m, logic rl, logic sv);
    logic f;
    logic [AW-1:0] r;
    f = 1'b0;
    if (m == 3'd1 || m == 3'd2 || m == 3'd3) begin
      if (t == 2'd1) f = a[9] ^ a[10];
      else if (t == 2'd2) f = a[9];
      if (t == 2'd1 || t == 2'd2) begin
        if (m == 3'd2) f = f ^ a[11];
        if (m == 3'd3) f = f ^ a[17];
      end
    end
    if (rl && (sv != a[17])) f = ~f;
    r = a;
    r[6] = a[6] ^ f;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // state carried between cycles for handshake checks
  bit            pushed_prev = 0;
  bit            stall_prev = 0;
  logic [AW-1:0] held_prev = '0;

  // one cycle: drive at negedge, sample after settling, edge follows
  task automatic cycle(bit v, logic [AW-1:0] a, logic [1:0] t, bit rl, bit sv,
                       bit rdy, string req);
    @(negedge clk);
    in_valid = v; in_addr = a; in_tile = t; in_reloc = rl;
    in_saved_b17 = sv; out_ready = rdy;
    #1;
    if (pushed_prev) chk(out_valid, "R9 latency", AW'(out_valid), AW'(1));
    if (stall_prev) begin
      chk(out_valid, "R9 hold valid", AW'(out_valid), AW'(1));
      chk(out_addr == held_prev, "R9 hold data", out_addr, held_prev);
    end
    chk(in_ready == (!out_valid || rdy), "R9 in_ready", AW'(in_ready),
        AW'(!out_valid || rdy));
    if (out_valid && rdy) begin
      if (expq.size() == 0) chk(0, "R9 spurious", out_addr, '0);
      else begin
        logic [AW-1:0] e;
        e = expq.pop_front();
        chk(out_addr == e, req, out_addr, e);
        chk(((out_addr ^ e) & ~(AW'(1) << 6)) == '0, "R8", out_addr, e);
      end
    end
    pushed_prev = v && in_ready;
    if (pushed_prev) expq.push_back(ref_addr(a, t, ref_mode(cfg_word), rl, sv));
    stall_prev = out_valid && !rdy;
    held_prev  = out_addr;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) cycle(0, '0, 2'd0, 0, 0, 1, "R9 drain");
    chk(expq.size() == 0, "R9 all delivered", AW'(expq.size()), '0);
  endtask

  task automatic set_cfg(logic [CW-1:0] w, string req);
    @(negedge clk);
    cfg_word = w;
    #1;
    chk(mode_code == ref_mode(w), req, AW'(mode_code), AW'(ref_mode(w)));
    chk(cfg_unknown == (ref_mode(w) == 3'd7), req, AW'(cfg_unknown),
        AW'(ref_mode(w) == 3'd7));
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    return {$urandom(), $urandom()};
  endfunction

  task automatic random_run(int n, string req, bit allow_reloc);
    for (int i = 0; i < n; i++) begin
      cycle(($urandom() % 4) != 0, rnd_addr(), 2'($urandom()),
            allow_reloc && $urandom() % 2 == 1, 1'($urandom()),
            ($urandom() % 3) != 0, req);
    end
    drain();
  endtask

  task automatic directed(string req);
    // every tap bit set, then each tap alone, both tilings and linear
    logic [AW-1:0] pats[6];
    pats[0] = AW'(40'h0_0002_0E00);
    pats[1] = AW'(40'h0_0000_0200);
    pats[2] = AW'(40'h0_0000_0400);
    pats[3] = AW'(40'h0_0000_0800);
    pats[4] = AW'(40'h0_0002_0040);
    pats[5] = '1;
    for (int p = 0; p < 6; p++)
      for (int t = 0; t < 4; t++)
        cycle(1, pats[p], 2'(t), 0, 0, 1, req);
    drain();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid", AW'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 idle", AW'({out_valid, in_ready}), AW'(1));

    set_cfg(32'h0000_0000, "R5 single");
    directed("R1 none mode");
    set_cfg(32'h0000_0001, "R5 asym");
    random_run(150, "R1 asym none", 0);
    set_cfg(32'h0000_0006, "R5 base");
    directed("R2 base");
    random_run(300, "R2 base random", 0);
    set_cfg(32'h0000_0002, "R5 bit11");
    directed("R3 bit11");
    random_run(300, "R3 bit11 random", 0);
    set_cfg(32'h0000_000A, "R5 bit17");
    directed("R4 bit17");
    random_run(300, "R4 bit17 random", 0);
    set_cfg(32'hFFF0_00F2, "R5 upper bits ignored");
    random_run(100, "R3 upper bits", 0);
    set_cfg(32'hFFFF_FFFF, "R6 all ones");
    directed("R6 unknown as none");
    set_cfg(32'h0000_0003, "R6 reserved arrangement");
    random_run(100, "R6 reserved none", 0);

    // relocation: flip only when saved bit differs from address bit 17
    set_cfg(32'h0000_0000, "R5 single");
    cycle(1, AW'(40'h0_0002_0000), 2'd0, 1, 0, 1, "R7 differ");
    cycle(1, AW'(40'h0_0002_0000), 2'd0, 1, 1, 1, "R7 equal");
    cycle(1, AW'(40'h0_0000_0040), 2'd0, 1, 1, 1, "R7 differ low");
    cycle(1, AW'(40'h0_0000_0040), 2'd0, 0, 1, 1, "R7 disabled");
    drain();
    set_cfg(32'h0000_000A, "R5 bit17");
    random_run(300, "R7 reloc with bit17", 1);
    set_cfg(32'h0000_0006, "R5 base");
    random_run(300, "R7 reloc with base", 1);

    // long stall: output must hold
    cycle(1, AW'(40'h12_3456_7A40), 2'd1, 0, 0, 0, "R9 stall");
    for (int i = 0; i < 5; i++) cycle(1, AW'(40'h0_0000_0600), 2'd2, 0, 0, 0, "R9 stall");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule